// File: doc/BRIEF.md
# Instruction Decoder and Control Unit

This block turns one 16-bit instruction word of a small non-pipelined 16-bit processor into the control signals that steer the datapath. Its outputs are two register read addresses, a write address, a write enable and a write-data source, an ALU operation code, a zero-extended immediate, memory read and write strobes, input and output port strobes, stack-pointer increment and decrement requests, a flag-update enable and a halt indication. Apart from halt, the path from the instruction to the outputs is purely combinational. The enclosing CPU presents one instruction per execution step and samples the controls in that same step.

Register-to-register arithmetic and logic always write to the fixed accumulator r1. Single-operand operations write their result back to the register they read. Stack operations use r13 as the address register without naming it. Read port A carries the memory address for loads, stores and stack accesses, and the jump target for jumps that read a register. Read port B carries the data that is stored to memory. With the default configuration, halt comes from a register: it latches the first halt instruction and holds until reset.

Top module: `insn_decoder`

## Requirements
- R1: The opcode is taken from bits 15:11, field F1 from bits 10:7 and field F2 from bits 6:3. Bits 2:0 are ignored. For every opcode not given an override below, rd_addr_a = F1 and rd_addr_b = F2.
- R2: mov (00001) asserts wr_en with wr_addr = F1, wr_src = 0 (ALU), alu_op = 0 (pass B) and flag_en low.
- R3: imm always equals bits 10:0 of the instruction, zero-extended to 16 bits. movi (00010) writes r1 with wr_src = 3 (immediate).
- R4: ldm (00011) asserts mem_rd, sets rd_addr_a = F2 and writes F1 from wr_src = 1 (memory). stm (00100) asserts mem_wr with rd_addr_a = F1 and rd_addr_b = F2, and does not write a register.
- R5: and (00101), or (00110), not (00111), add (01010) and sub (01011) write r1 from the ALU with alu_op 1, 2, 3, 4 and 5 respectively.
- R6: inc (01000), dec (01001), shift left (01100), shift right (01101) and rotate right (01110) write F1 from the ALU with alu_op 6, 7, 8, 9 and 10 respectively.
- R7: push (11101) sets rd_addr_a = 13 and rd_addr_b = F1 and asserts mem_wr and sp_inc. pop (11110) sets rd_addr_a = 13, asserts mem_rd and sp_dec, and writes F1 with wr_src = 1.
- R8: in (11001) asserts port_rd and writes F1 with wr_src = 2 (port). out (11010) asserts port_wr and writes no register.
- R9: Jump opcodes 01111 to 11000 assert no strobe and no flag update. call (10111) writes r2 with wr_src = 4 (link). ret (11000) sets rd_addr_a = 2. No other jump writes a register.
- R10: Opcodes 00000, 11011 (halt), 11100 (nop) and 11111 assert none of wr_en, flag_en, mem_rd, mem_wr, port_rd, port_wr, sp_inc or sp_dec.
- R11: halt is low after a synchronous reset. It rises in the cycle after a rising clock edge that samples opcode 11011 and stays high until rst.
- R12: flag_en is high for exactly the ten ALU opcodes of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| rd_addr_a | output | 4 | Read port A address (address or jump target) |
| rd_addr_b | output | 4 | Read port B address (second operand or store data) |
| wr_addr | output | 4 | Register write address |
| wr_en | output | 1 | Register write enable |
| wr_src | output | 3 | Write-data source: 0 ALU, 1 memory, 2 port, 3 immediate, 4 link |
| alu_op | output | 4 | ALU operation select |
| imm | output | 16 | Zero-extended immediate |
| flag_en | output | 1 | Update the condition flags |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| port_rd | output | 1 | External input port strobe |
| port_wr | output | 1 | External output port strobe |
| sp_inc | output | 1 | Increment r13 |
| sp_dec | output | 1 | Decrement r13 |
| halt | output | 1 | Processor halted |

## Verification
A wrong entry in the opcode table shows up at once, in the same step, as a wrong strobe, address or source select for that opcode. In a CPU it would silently corrupt a register, memory or the flags, so every opcode is swept with several field patterns and each output group is compared. A fault in the halt register shows one cycle after the edge: halt either fails to rise, does not stay high once the instruction word changes, or stays high after reset.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_NULL = 5'd0,  OP_MOV  = 5'd1,  OP_MOVI = 5'd2,  OP_LDM  = 5'd3,
    OP_STM  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_NOT  = 5'd7,
    OP_INC  = 5'd8,  OP_DEC  = 5'd9,  OP_ADD  = 5'd10, OP_SUB  = 5'd11,
    OP_SHL  = 5'd12, OP_SHR  = 5'd13, OP_ROR  = 5'd14, OP_JMP  = 5'd15,
    OP_JMPR = 5'd16, OP_JZ   = 5'd17, OP_JZR  = 5'd18, OP_JNZ  = 5'd19,
    OP_JNZR = 5'd20, OP_JP   = 5'd21, OP_JPR  = 5'd22, OP_CALL = 5'd23,
    OP_RET  = 5'd24, OP_IN   = 5'd25, OP_OUT  = 5'd26, OP_HALT = 5'd27,
    OP_NOP  = 5'd28, OP_PUSH = 5'd29, OP_POP  = 5'd30, OP_RSVD = 5'd31
  } opc_e;

  typedef enum logic [3:0] {
    ALU_PASS_B = 4'd0, ALU_AND = 4'd1, ALU_OR  = 4'd2, ALU_NOT = 4'd3,
    ALU_ADD    = 4'd4, ALU_SUB = 4'd5, ALU_INC = 4'd6, ALU_DEC = 4'd7,
    ALU_SHL    = 4'd8, ALU_SHR = 4'd9, ALU_ROR = 4'd10
  } alu_e;

  typedef enum logic [2:0] {
    WS_ALU = 3'd0, WS_MEM = 3'd1, WS_PORT = 3'd2, WS_IMM = 3'd3, WS_LINK = 3'd4
  } wsrc_e;

  typedef enum logic [1:0] {RA_F1, RA_F2, RA_SP, RA_LINK} rasel_e;
  typedef enum logic [0:0] {RB_F2, RB_F1} rbsel_e;
  typedef enum logic [1:0] {WA_F1, WA_ACC, WA_LINK} wasel_e;

  typedef struct packed {
    rasel_e ra_sel;
    rbsel_e rb_sel;
    wasel_e wa_sel;
    logic   wr_en;
    wsrc_e  wr_src;
    alu_e   alu_op;
    logic   flag_en;
    logic   mem_rd;
    logic   mem_wr;
    logic   port_rd;
    logic   port_wr;
    logic   sp_inc;
    logic   sp_dec;
    logic   halt;
  } ctrl_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields #(
  parameter int INSN_W = 16,
  parameter int REG_AW = 4,
  parameter int DATA_W = 16
) (
  input  logic [INSN_W-1:0]              instr,
  output logic [idec_pkg::OPC_W-1:0]     opc,
  output logic [REG_AW-1:0]              f1,
  output logic [REG_AW-1:0]              f2,
  output logic [DATA_W-1:0]              imm
);
  localparam int OPC_LO = INSN_W - idec_pkg::OPC_W;
  localparam int IMM_W  = OPC_LO;
  localparam int F1_HI  = OPC_LO - 1;
  localparam int F2_HI  = F1_HI - REG_AW;

  assign opc = instr[INSN_W-1 -: idec_pkg::OPC_W];
  assign f1  = instr[F1_HI -: REG_AW];
  assign f2  = instr[F2_HI -: REG_AW];
  assign imm = {{(DATA_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};
endmodule

// File: rtl/idec_table.sv
module idec_table
  import idec_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl = '0;
    case (opc)
      OP_MOV:  begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_PASS_B; end
      OP_MOVI: begin ctrl.wr_en = 1'b1; ctrl.wa_sel = WA_ACC; ctrl.wr_src = WS_IMM; end
      OP_LDM:  begin
        ctrl.ra_sel = RA_F2; ctrl.wr_en = 1'b1; ctrl.wr_src = WS_MEM; ctrl.mem_rd = 1'b1;
      end
      OP_STM:  ctrl.mem_wr = 1'b1;
      OP_AND, OP_OR, OP_NOT, OP_ADD, OP_SUB: begin
        ctrl.wr_en = 1'b1; ctrl.wa_sel = WA_ACC; ctrl.flag_en = 1'b1;
        case (opc)
          OP_AND:  ctrl.alu_op = ALU_AND;
          OP_OR:   ctrl.alu_op = ALU_OR;
          OP_NOT:  ctrl.alu_op = ALU_NOT;
          OP_ADD:  ctrl.alu_op = ALU_ADD;
          default: ctrl.alu_op = ALU_SUB;
        endcase
      end
      OP_INC, OP_DEC, OP_SHL, OP_SHR, OP_ROR: begin
        ctrl.wr_en = 1'b1; ctrl.flag_en = 1'b1;
        case (opc)
          OP_INC:  ctrl.alu_op = ALU_INC;
          OP_DEC:  ctrl.alu_op = ALU_DEC;
          OP_SHL:  ctrl.alu_op = ALU_SHL;
          OP_SHR:  ctrl.alu_op = ALU_SHR;
          default: ctrl.alu_op = ALU_ROR;
        endcase
      end
      OP_CALL: begin ctrl.wr_en = 1'b1; ctrl.wa_sel = WA_LINK; ctrl.wr_src = WS_LINK; end
      OP_RET:  ctrl.ra_sel = RA_LINK;
      OP_IN:   begin ctrl.wr_en = 1'b1; ctrl.wr_src = WS_PORT; ctrl.port_rd = 1'b1; end
      OP_OUT:  ctrl.port_wr = 1'b1;
      OP_HALT: ctrl.halt = 1'b1;
      OP_PUSH: begin
        ctrl.ra_sel = RA_SP; ctrl.rb_sel = RB_F1; ctrl.mem_wr = 1'b1; ctrl.sp_inc = 1'b1;
      end
      OP_POP:  begin
        ctrl.ra_sel = RA_SP; ctrl.wr_en = 1'b1; ctrl.wr_src = WS_MEM;
        ctrl.mem_rd = 1'b1; ctrl.sp_dec = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/idec_halt.sv
module idec_halt #(
  parameter bit HALT_REG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic dec_halt,
  output logic halt
);
  generate
    if (HALT_REG) begin : g_reg
      logic halt_q;
      always_ff @(posedge clk) begin
        if (rst)           halt_q <= 1'b0;
        else if (dec_halt) halt_q <= 1'b1;
      end
      assign halt = halt_q;

      a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt)
        else $error("a_r11_halt_sticky");
      a_r11_halt_cause: assert property (@(posedge clk) disable iff (rst)
        dec_halt |=> halt)
        else $error("a_r11_halt_cause");
    end else begin : g_comb
      assign halt = dec_halt;
    end
  endgenerate
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import idec_pkg::*;
#(
  parameter int INSN_W   = 16,
  parameter int REG_AW   = 4,
  parameter int DATA_W   = 16,
  parameter int ACC_IDX  = 1,
  parameter int LINK_IDX = 2,
  parameter int SP_IDX   = 13,
  parameter bit HALT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] instr,
  output logic [REG_AW-1:0] rd_addr_a,
  output logic [REG_AW-1:0] rd_addr_b,
  output logic [REG_AW-1:0] wr_addr,
  output logic              wr_en,
  output logic [2:0]        wr_src,
  output logic [3:0]        alu_op,
  output logic [DATA_W-1:0] imm,
  output logic              flag_en,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              port_rd,
  output logic              port_wr,
  output logic              sp_inc,
  output logic              sp_dec,
  output logic              halt
);
  localparam logic [REG_AW-1:0] ACC_A  = REG_AW'(ACC_IDX);
  localparam logic [REG_AW-1:0] LINK_A = REG_AW'(LINK_IDX);
  localparam logic [REG_AW-1:0] SP_A   = REG_AW'(SP_IDX);

  logic [OPC_W-1:0]  opc;
  logic [REG_AW-1:0] f1, f2;
  ctrl_t             ctrl;

  idec_fields #(.INSN_W(INSN_W), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_fields (
    .instr(instr), .opc(opc), .f1(f1), .f2(f2), .imm(imm)
  );

  idec_table u_table (.opc(opc), .ctrl(ctrl));

  idec_halt #(.HALT_REG(HALT_REG)) u_halt (
    .clk(clk), .rst(rst), .dec_halt(ctrl.halt), .halt(halt)
  );

  always_comb begin
    case (ctrl.ra_sel)
      RA_F2:   rd_addr_a = f2;
      RA_SP:   rd_addr_a = SP_A;
      RA_LINK: rd_addr_a = LINK_A;
      default: rd_addr_a = f1;
    endcase
    rd_addr_b = (ctrl.rb_sel == RB_F1) ? f1 : f2;
    case (ctrl.wa_sel)
      WA_ACC:  wr_addr = ACC_A;
      WA_LINK: wr_addr = LINK_A;
      default: wr_addr = f1;
    endcase
  end

  assign wr_en   = ctrl.wr_en;
  assign wr_src  = ctrl.wr_src;
  assign alu_op  = ctrl.alu_op;
  assign flag_en = ctrl.flag_en;
  assign mem_rd  = ctrl.mem_rd;
  assign mem_wr  = ctrl.mem_wr;
  assign port_rd = ctrl.port_rd;
  assign port_wr = ctrl.port_wr;
  assign sp_inc  = ctrl.sp_inc;
  assign sp_dec  = ctrl.sp_dec;

  a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, port_rd, port_wr}))
    else $error("a_r4_strobe_onehot");
  a_r7_push_addr: assert property (@(posedge clk) disable iff (rst)
    sp_inc |-> (mem_wr && rd_addr_a == SP_A && !wr_en))
    else $error("a_r7_push_addr");
  a_r7_pop_addr: assert property (@(posedge clk) disable iff (rst)
    sp_dec |-> (mem_rd && rd_addr_a == SP_A && wr_en && wr_src == WS_MEM))
    else $error("a_r7_pop_addr");
  a_r12_flag_alu: assert property (@(posedge clk) disable iff (rst)
    flag_en |-> (wr_en && wr_src == WS_ALU && !mem_rd && !port_rd))
    else $error("a_r12_flag_alu");
  a_r5_acc_target: assert property (@(posedge clk) disable iff (rst)
    (flag_en && wr_addr != rd_addr_a) |-> (wr_addr == ACC_A))
    else $error("a_r5_acc_target");
endmodule

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0;
  logic [3:0]  rd_addr_a, rd_addr_b, wr_addr, alu_op;
  logic        wr_en, flag_en, mem_rd, mem_wr, port_rd, port_wr, sp_inc, sp_dec, halt;
  logic [2:0]  wr_src;
  logic [15:0] imm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  insn_decoder dut (
    .clk(clk), .rst(rst), .instr(instr),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_addr(wr_addr),
    .wr_en(wr_en), .wr_src(wr_src), .alu_op(alu_op), .imm(imm),
    .flag_en(flag_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .port_rd(port_rd), .port_wr(port_wr), .sp_inc(sp_inc), .sp_dec(sp_dec),
    .halt(halt)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic string tag(input int op);
    if (op == 1) return "R2";
    if (op == 2) return "R3";
    if (op == 3 || op == 4) return "R4";
    if (op == 5 || op == 6 || op == 7 || op == 10 || op == 11) return "R5";
    if (op == 8 || op == 9 || (op >= 12 && op <= 14)) return "R6";
    if (op >= 15 && op <= 24) return "R9";
    if (op == 25 || op == 26) return "R8";
    if (op == 29 || op == 30) return "R7";
    return "R10";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R11 halt after reset", int'(halt), 0);
    rst = 1'b0;

    for (int op = 0; op < 32; op++) begin
      for (int p = 0; p < 5; p++) begin
        int f1, f2, lo, ea, eb, wa, ws, al;
        bit we, fl, mrd, mwr, prd, pwr, spi, spd;
        string t;
        f1 = (p * 5 + op) % 16;
        f2 = (p * 11 + 3 + op) % 16;
        lo = (p * 3 + op) % 8;
        @(negedge clk);
        instr = {op[4:0], f1[3:0], f2[3:0], lo[2:0]};
        #1;
        ea = f1; eb = f2; we = 0; wa = 0; ws = 0; al = -1;
        fl = 0; mrd = 0; mwr = 0; prd = 0; pwr = 0; spi = 0; spd = 0;
        case (op)
          1:  begin we = 1; wa = f1; ws = 0; al = 0; end
          2:  begin we = 1; wa = 1; ws = 3; end
          3:  begin ea = f2; we = 1; wa = f1; ws = 1; mrd = 1; end
          4:  mwr = 1;
          5, 6, 7, 10, 11: begin
            we = 1; wa = 1; ws = 0; fl = 1;
            al = (op == 5) ? 1 : (op == 6) ? 2 : (op == 7) ? 3 : (op == 10) ? 4 : 5;
          end
          8, 9, 12, 13, 14: begin
            we = 1; wa = f1; ws = 0; fl = 1;
            al = (op == 8) ? 6 : (op == 9) ? 7 : (op == 12) ? 8 : (op == 13) ? 9 : 10;
          end
          23: begin we = 1; wa = 2; ws = 4; end
          24: ea = 2;
          25: begin we = 1; wa = f1; ws = 2; prd = 1; end
          26: pwr = 1;
          29: begin ea = 13; eb = f1; mwr = 1; spi = 1; end
          30: begin ea = 13; we = 1; wa = f1; ws = 1; mrd = 1; spd = 1; end
          default: ;
        endcase
        t = $sformatf("%s op=%0d", tag(op), op);
        chk({t, " R1 rd_addr_a"}, int'(rd_addr_a), ea);
        chk({t, " R1 rd_addr_b"}, int'(rd_addr_b), eb);
        chk({t, " wr_en"}, int'(wr_en), int'(we));
        if (we) begin
          chk({t, " wr_addr"}, int'(wr_addr), wa);
          chk({t, " wr_src"}, int'(wr_src), ws);
        end
        if (al >= 0) chk({t, " alu_op"}, int'(alu_op), al);
        chk({t, " R12 flag_en"}, int'(flag_en), int'(fl));
        chk({t, " strobes"}, int'({mem_rd, mem_wr, port_rd, port_wr, sp_inc, sp_dec}),
            int'({mrd, mwr, prd, pwr, spi, spd}));
        chk({t, " R3 imm"}, int'(imm), int'(instr[10:0]));
      end
    end

    // R11: registered, sticky halt
    @(negedge clk); rst = 1'b1; instr = {5'd28, 11'd0};
    @(negedge clk); rst = 1'b0;
    #1 chk("R11 halt low after reset pulse", int'(halt), 0);
    @(negedge clk); instr = {5'd27, 11'h5a5};
    #1 chk("R11 halt not yet registered", int'(halt), 0);
    @(negedge clk); instr = {5'd28, 11'd0};
    #1 chk("R11 halt rises after edge", int'(halt), 1);
    repeat (5) @(negedge clk);
    #1 chk("R11 halt held", int'(halt), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    #1 chk("R11 halt cleared by reset", int'(halt), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule